// File: doc/BRIEF.md
# Flash Status Toggle-Bit Generator

This block drives the two toggling status bits that a parallel flash device returns while an embedded program or erase runs. A host polls the device by reading it repeatedly; each new read cycle flips the bits that are qualified at that moment. The host compares two reads in a row to tell whether an operation is still running. The mode bit (bit 6 of the returned byte) reports whether any embedded operation is in progress. The sector bit (bit 2) reports whether the sector being read is one that an erase has selected.

The memory array, the command decoder and the real algorithm timing sit outside this block. They appear here as plain flags: program busy, erase busy, erase suspended, a command-accept pulse with its kind and target sector, and per-sector erase-select and protect masks. When a program targets a protected sector, or an erase selects only protected sectors, no work is done. The block still shows a busy status for a fixed window, timed by a cycle counter. When nothing is running, the array data input passes straight through to the output.

Top module: `ffs_status_gen`

## Requirements
- R1: After reset both toggle bits are 0 and the window counter is empty, so an idle device returns array data and the first status byte shown reads 0x00.
- R2: While the mode qualifier holds (program busy, erase busy and not suspended, or a protection window running), bit 6 of the output inverts once per read cycle, whatever sector is addressed.
- R3: A read cycle is the interval in which output-enable and chip-enable are both low, and either strobe may be the one that opens or closes it. The bits step once when a cycle opens and hold for the rest of that cycle.
- R4: During erase suspend with no program running, bit 6 holds its value across reads. A program started inside the suspend makes bit 6 invert on every read again.
- R5: Bit 2 inverts on a read only when an erase is busy or suspended and the addressed sector is selected for erase and not protected. Reads of unselected or protected sectors leave it unchanged.
- R6: A program command whose target sector is protected shows status for exactly PROG_CYC clock cycles after the accept edge, then returns to array data.
- R7: An erase command that selects at least one sector, all of them protected, shows status for exactly ERASE_CYC cycles. Any other erase command starts no window.
- R8: Every accepted command reloads the window counter. A command that does not hit the protection case clears a running window, and a new protected command restarts it at its own length.
- R9: Whenever status is shown, the output carries bit 6 and bit 2 from the toggle bits and 0 in every other bit. Status is shown while the mode qualifier holds, or while an erase is suspended and the read sector is one selected and unprotected. Otherwise the output equals the array data input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| oe_n | input | 1 | Output-enable strobe, active low |
| ce_n | input | 1 | Chip-enable strobe, active low |
| rd_sector | input | $clog2(NSEC) | Sector of the current read address |
| array_data | input | DW | Array contents at the read address |
| erase_sel | input | NSEC | Per-sector erase-selected flags |
| prot | input | NSEC | Per-sector protection flags |
| prog_busy | input | 1 | Embedded program in progress |
| erase_busy | input | 1 | Embedded erase in progress (possibly suspended) |
| erase_susp | input | 1 | Erase is suspended |
| cmd_accept | input | 1 | One-cycle pulse: a program or erase command was accepted |
| cmd_is_erase | input | 1 | Kind of accepted command: 1 erase, 0 program |
| cmd_sector | input | $clog2(NSEC) | Target sector of an accepted program |
| dq_out | output | DW | Returned read data or status byte |

## Verification
The bench builds the block with four sectors, a 10 MHz setting, a 500 ns program window and a 2000 ns erase window. That makes the windows 5 and 20 cycles long, so each one can be counted edge by edge. With four sectors, all 256 pairs of erase-select and protect masks can be swept. Each pair checks whether the all-protected window starts and whether bit 2 steps on a read of each sector. Suspend, suspend-program, window reload and both strobe orderings are driven in directed sequences and compared against a reference model kept in the bench.

// File: rtl/ffs_pkg.sv
package ffs_pkg;

  // Output bit positions decoded by the host polling routine
  localparam int unsigned MODE_BIT = 6;
  localparam int unsigned SECT_BIT = 2;

  // Number of toggle cells (mode, sector)
  localparam int unsigned NUM_TOG  = 2;
  localparam int unsigned TOG_MODE = 0;
  localparam int unsigned TOG_SECT = 1;

  // Round a duration up to whole clock cycles
  function automatic int unsigned ns_to_cycles(input int unsigned mhz,
                                               input int unsigned ns);
    return (mhz * ns + 999) / 1000;
  endfunction

endpackage

// File: rtl/ffs_read_edge.sv
module ffs_read_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic oe_n,
  input  logic ce_n,
  output logic rd_start
);

  logic rd_on;
  logic prev_q;
  logic prev_d;

  // A read cycle needs both strobes asserted; either may arrive last
  assign rd_on = ~oe_n & ~ce_n;

  always_comb begin
    prev_d = rd_on;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
    end
  end

  assign rd_start = rd_on & ~prev_q;

endmodule

// File: rtl/ffs_win_timer.sv
module ffs_win_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          active,
  output logic [CW-1:0] count
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  // Every accepted command reloads; otherwise count down to zero
  always_comb begin
    cnt_en = load | (cnt_q != '0);
    cnt_d  = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign active = (cnt_q != '0);
  assign count  = cnt_q;

endmodule

// File: rtl/ffs_toggle_cell.sv
module ffs_toggle_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  output logic q
);

  logic q_q;
  logic q_d;

  always_comb begin
    q_d = q_q;
    if (step) begin
      q_d = ~q_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q <= 1'b0;
    end else if (step) begin
      q_q <= q_d;
    end
  end

  assign q = q_q;

endmodule

// File: rtl/ffs_status_gen.sv
module ffs_status_gen #(
  parameter int unsigned NSEC         = 8,
  parameter int unsigned CLK_MHZ      = 100,
  parameter int unsigned PROG_WIN_NS  = 1000,
  parameter int unsigned ERASE_WIN_NS = 100000,
  parameter int unsigned DW           = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    oe_n,
  input  logic                    ce_n,
  input  logic [$clog2(NSEC)-1:0] rd_sector,
  input  logic [DW-1:0]           array_data,
  input  logic [NSEC-1:0]         erase_sel,
  input  logic [NSEC-1:0]         prot,
  input  logic                    prog_busy,
  input  logic                    erase_busy,
  input  logic                    erase_susp,
  input  logic                    cmd_accept,
  input  logic                    cmd_is_erase,
  input  logic [$clog2(NSEC)-1:0] cmd_sector,
  output logic [DW-1:0]           dq_out
);

  import ffs_pkg::*;

  localparam int unsigned PROG_CYC  = ns_to_cycles(CLK_MHZ, PROG_WIN_NS);
  localparam int unsigned ERASE_CYC = ns_to_cycles(CLK_MHZ, ERASE_WIN_NS);
  localparam int unsigned MAX_CYC   = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int unsigned CW        = $clog2(MAX_CYC + 1);

  // ---------------------------------------------------------------
  // Read-cycle framing
  // ---------------------------------------------------------------
  logic rd_start;

  ffs_read_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .oe_n     (oe_n),
    .ce_n     (ce_n),
    .rd_start (rd_start)
  );

  // ---------------------------------------------------------------
  // Protection windows
  // ---------------------------------------------------------------
  logic [NSEC-1:0] eff_sel;
  logic            prog_prot_hit;
  logic            erase_all_prot;
  logic [CW-1:0]   win_load;
  logic [CW-1:0]   win_cnt;
  logic            win_on;

  assign eff_sel        = erase_sel & ~prot;
  assign prog_prot_hit  = prot[cmd_sector];
  assign erase_all_prot = (|erase_sel) & ~(|eff_sel);

  always_comb begin
    win_load = '0;
    if (cmd_is_erase) begin
      if (erase_all_prot) begin
        win_load = CW'(ERASE_CYC);
      end
    end else if (prog_prot_hit) begin
      win_load = CW'(PROG_CYC);
    end
  end

  ffs_win_timer #(.CW(CW)) u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cmd_accept),
    .load_val (win_load),
    .active   (win_on),
    .count    (win_cnt)
  );

  // ---------------------------------------------------------------
  // Toggle qualifiers and cells
  // ---------------------------------------------------------------
  logic               sect_hit;
  logic               mode_qual;
  logic               sect_qual;
  logic [NUM_TOG-1:0] tog_qual;
  logic [NUM_TOG-1:0] tq;

  assign sect_hit  = eff_sel[rd_sector];
  assign mode_qual = prog_busy | (erase_busy & ~erase_susp) | win_on;
  assign sect_qual = (erase_busy | erase_susp) & sect_hit;

  always_comb begin
    tog_qual           = '0;
    tog_qual[TOG_MODE] = mode_qual;
    tog_qual[TOG_SECT] = sect_qual;
  end

  for (genvar g = 0; g < NUM_TOG; g++) begin : g_tog
    ffs_toggle_cell u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (rd_start & tog_qual[g]),
      .q     (tq[g])
    );
  end

  // ---------------------------------------------------------------
  // Output selection
  // ---------------------------------------------------------------
  logic          show_status;
  logic [DW-1:0] status_byte;

  assign show_status = mode_qual | (erase_susp & sect_hit);

  always_comb begin
    status_byte           = '0;
    status_byte[MODE_BIT] = tq[TOG_MODE];
    status_byte[SECT_BIT] = tq[TOG_SECT];
  end

  assign dq_out = show_status ? status_byte : array_data;

endmodule

// File: rtl/ffs_checker.sv
module ffs_checker #(
  parameter int unsigned NSEC      = 8,
  parameter int unsigned DW        = 8,
  parameter int unsigned CW        = 8,
  parameter int unsigned PROG_CYC  = 100,
  parameter int unsigned ERASE_CYC = 10000
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    rd_start,
  input logic                    mode_qual,
  input logic                    sect_qual,
  input logic [1:0]              tq,
  input logic [CW-1:0]           win_cnt,
  input logic                    cmd_accept,
  input logic                    cmd_is_erase,
  input logic [$clog2(NSEC)-1:0] cmd_sector,
  input logic [NSEC-1:0]         erase_sel,
  input logic [NSEC-1:0]         prot,
  input logic                    prog_busy,
  input logic                    erase_busy,
  input logic                    erase_susp,
  input logic [DW-1:0]           dq_out,
  input logic [DW-1:0]           array_data
);

  // R2: mode bit steps on a qualified read start
  a_r2_mode_flip: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start && mode_qual |=> tq[0] != $past(tq[0]));

  // R5: sector bit steps on a qualified read start
  a_r5_sect_flip: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start && sect_qual |=> tq[1] != $past(tq[1]));

  // R3: nothing steps without the opening of a read cycle
  a_r3_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_start |=> $stable(tq));

  // R4: suspended erase with no program and no window freezes the mode bit
  a_r4_susp_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    erase_susp && !prog_busy && (win_cnt == '0) |=> $stable(tq[0]));

  // R6: protected program loads the short window
  a_r6_prog_window: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept && !cmd_is_erase && prot[cmd_sector] |=> win_cnt == CW'(PROG_CYC));

  // R7: all-protected erase loads the long window
  a_r7_erase_window: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept && cmd_is_erase && (|erase_sel) && !(|(erase_sel & ~prot))
    |=> win_cnt == CW'(ERASE_CYC));

  // R8: without a new command a running window counts down by one
  a_r8_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (win_cnt != '0) && !cmd_accept |=> win_cnt == $past(win_cnt) - 1'b1);

  // R9: idle device passes array data through
  a_r9_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_busy && !erase_busy && !erase_susp && (win_cnt == '0) |-> dq_out == array_data);

endmodule

bind ffs_status_gen ffs_checker #(
  .NSEC      (NSEC),
  .DW        (DW),
  .CW        (CW),
  .PROG_CYC  (PROG_CYC),
  .ERASE_CYC (ERASE_CYC)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rd_start     (rd_start),
  .mode_qual    (mode_qual),
  .sect_qual    (sect_qual),
  .tq           (tq),
  .win_cnt      (win_cnt),
  .cmd_accept   (cmd_accept),
  .cmd_is_erase (cmd_is_erase),
  .cmd_sector   (cmd_sector),
  .erase_sel    (erase_sel),
  .prot         (prot),
  .prog_busy    (prog_busy),
  .erase_busy   (erase_busy),
  .erase_susp   (erase_susp),
  .dq_out       (dq_out),
  .array_data   (array_data)
);

// File: tb/sim_ffs_status_gen.sv
module sim_ffs_status_gen;

  localparam int NSEC  = 4;
  localparam int SW    = 2;
  localparam int PWIN  = 5;   // 10 MHz * 500 ns
  localparam int EWIN  = 20;  // 10 MHz * 2000 ns
  localparam logic [7:0] ARR = 8'h3B;

  logic            clk;
  logic            rst_n;
  logic            oe_n, ce_n;
  logic [SW-1:0]   rd_sector;
  logic [7:0]      array_data;
  logic [NSEC-1:0] erase_sel, prot;
  logic            prog_busy, erase_busy, erase_susp;
  logic            cmd_accept, cmd_is_erase;
  logic [SW-1:0]   cmd_sector;
  logic [7:0]      dq_out;

  int n_chk  = 0;
  int n_fail = 0;

  ffs_status_gen #(
    .NSEC(NSEC), .CLK_MHZ(10), .PROG_WIN_NS(500), .ERASE_WIN_NS(2000), .DW(8)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .ce_n(ce_n), .rd_sector(rd_sector),
    .array_data(array_data), .erase_sel(erase_sel), .prot(prot),
    .prog_busy(prog_busy), .erase_busy(erase_busy), .erase_susp(erase_susp),
    .cmd_accept(cmd_accept), .cmd_is_erase(cmd_is_erase), .cmd_sector(cmd_sector),
    .dq_out(dq_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // ---------------- reference model from the requirements ----------------
  logic m6, m2, m_prev;
  int   m_cnt;

  function automatic logic f_sel(input int s);
    return erase_sel[s] & ~prot[s];
  endfunction

  function automatic logic f_mode();
    return prog_busy | (erase_busy & ~erase_susp) | (m_cnt != 0);
  endfunction

  function automatic logic f_sect();
    return (erase_busy | erase_susp) & f_sel(int'(rd_sector));
  endfunction

  function automatic logic [7:0] f_exp();
    logic [7:0] st;
    st = 8'h00;
    st[6] = m6;
    st[2] = m2;
    if (f_mode() || (erase_susp && f_sel(int'(rd_sector)))) return st;
    return array_data;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m6 <= 1'b0; m2 <= 1'b0; m_prev <= 1'b0; m_cnt <= 0;
    end else begin
      logic on;
      on = ~oe_n & ~ce_n;
      m_prev <= on;
      if (on && !m_prev && f_mode()) m6 <= ~m6;
      if (on && !m_prev && f_sect()) m2 <= ~m2;
      if (cmd_accept) begin
        if (cmd_is_erase)
          m_cnt <= ((erase_sel != 0) && ((erase_sel & ~prot) == 0)) ? EWIN : 0;
        else
          m_cnt <= prot[cmd_sector] ? PWIN : 0;
      end else if (m_cnt != 0) begin
        m_cnt <= m_cnt - 1;
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input string req, input logic [7:0] exp);
    n_chk++;
    if (dq_out !== exp) begin
      n_fail++;
      $display("FAIL %s: dq_out=%02h expected=%02h at %0t", req, dq_out, exp, $time);
    end
  endtask

  task automatic check_int(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // one read: order 0 both together, 1 oe first, 2 ce first
  task automatic do_read(input string req, input int sec, input int order);
    @(negedge clk);
    rd_sector = SW'(sec);
    if (order == 1) begin oe_n = 1'b0; @(negedge clk); ce_n = 1'b0; end
    else if (order == 2) begin ce_n = 1'b0; @(negedge clk); oe_n = 1'b0; end
    else begin oe_n = 1'b0; ce_n = 1'b0; end
    @(negedge clk);
    check(req, f_exp());
    oe_n = 1'b1; ce_n = 1'b1;
  endtask

  task automatic issue(input logic is_er, input int sec);
    @(negedge clk);
    cmd_accept = 1'b1; cmd_is_erase = is_er; cmd_sector = SW'(sec);
    @(negedge clk);
    cmd_accept = 1'b0;
  endtask

  task automatic win_len(input string req, input int exp);
    int n;
    n = 0;
    while (dq_out != array_data && n < 100) begin
      n++;
      @(negedge clk);
    end
    check_int(req, n, exp);
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    report();
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    rst_n = 1'b0; oe_n = 1'b1; ce_n = 1'b1; rd_sector = '0;
    array_data = ARR; erase_sel = '0; prot = '0;
    prog_busy = 1'b0; erase_busy = 1'b0; erase_susp = 1'b0;
    cmd_accept = 1'b0; cmd_is_erase = 1'b0; cmd_sector = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: idle pass-through and reset status value
    check("R1 idle", ARR);
    do_read("R1 idle read", 1, 0);
    check("R1 idle after read", ARR);
    prog_busy = 1'b1;
    @(negedge clk);
    check("R1 first status", 8'h00);

    // R2: program busy, reads at every sector
    for (int i = 0; i < 8; i++) do_read("R2 program read", i % NSEC, 0);
    prog_busy = 1'b0;
    erase_busy = 1'b1; erase_sel = 4'b0000;
    for (int i = 0; i < 4; i++) do_read("R2 erase read", i, 0);

    // R3: strobe ordering and long cycles
    do_read("R3 oe first", 0, 1);
    do_read("R3 ce first", 2, 2);
    @(negedge clk);
    oe_n = 1'b0; ce_n = 1'b0;
    @(negedge clk);
    check("R3 long open", f_exp());
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R3 long hold", f_exp());
    end
    ce_n = 1'b1;                  // close with chip-enable, oe stays low
    @(negedge clk);
    ce_n = 1'b0;                  // reopen with chip-enable
    @(negedge clk);
    check("R3 ce reframe", f_exp());
    oe_n = 1'b1; ce_n = 1'b1;
    erase_busy = 1'b0;

    // R4: suspend and suspend-program
    erase_sel = 4'b0011; prot = 4'b0000;
    erase_busy = 1'b1; erase_susp = 1'b1;
    for (int i = 0; i < 3; i++) do_read("R4 susp selected", 0, 0);
    do_read("R4 susp unselected gives array", 3, 0);
    prog_busy = 1'b1;
    for (int i = 0; i < 3; i++) do_read("R4 susp program", 3, 0);
    prog_busy = 1'b0; erase_susp = 1'b0; erase_busy = 1'b0;

    // R9: erase busy, unselected sector still shows status, bit 2 frozen
    erase_busy = 1'b1;
    for (int i = 0; i < 3; i++) do_read("R9 busy unselected", 2, 0);
    erase_busy = 1'b0;

    // R6: protected program window
    erase_sel = 4'b0000; prot = 4'b0100;
    issue(1'b0, 2);
    win_len("R6 program window", PWIN);
    issue(1'b0, 2);
    do_read("R6 read in window", 1, 0);
    do_read("R6 read in window", 3, 0);
    repeat (6) @(negedge clk);
    check("R6 after window", ARR);
    issue(1'b0, 1);
    check("R6 unprotected no window", ARR);

    // R8: reload and clear
    erase_sel = 4'b0001; prot = 4'b0001;
    issue(1'b1, 0);
    repeat (3) @(negedge clk);
    issue(1'b0, 0);
    win_len("R8 reload to program length", PWIN);
    issue(1'b1, 0);
    repeat (2) @(negedge clk);
    issue(1'b0, 1);
    check("R8 clear by unprotected", ARR);

    // R5 / R7: sweep all select and protect masks
    for (int s = 0; s < 16; s++) begin
      for (int p = 0; p < 16; p++) begin
        logic allp;
        @(negedge clk);
        erase_sel = NSEC'(s); prot = NSEC'(p);
        allp = (s != 0) && ((s & ~p & 15) == 0);
        issue(1'b1, 0);
        check("R7 sweep", f_exp());
        check_int("R7 sweep window", int'(dq_out != array_data), int'(allp));
        erase_sel = '0;
        issue(1'b1, 0);           // clears any window
        erase_sel = NSEC'(s);
        erase_busy = 1'b1;
        for (int r = 0; r < NSEC; r++) do_read("R5 sweep read", r, 0);
        erase_busy = 1'b0;
      end
    end

    // R7: full window length once
    erase_sel = 4'b1010; prot = 4'b1110;
    issue(1'b1, 0);
    win_len("R7 erase window", EWIN);

    report();
    $finish;
  end

endmodule